// File: doc/BRIEF.md
# Planar YUV Chroma Decimating Splitter

This block takes a stream of full-resolution pixels that each carry one luma byte and two chroma bytes (U and V). It separates them into three planar byte streams, one each for luma, U and V. Each stream has its own packer that builds 32-bit words and writes them into a separate downstream FIFO. Luma is always kept in full. Chroma is thinned by keeping the sample at one fixed position of each block and dropping the rest; no averaging is done. A two-bit mode input selects the pattern: every pixel, the left pixel of each horizontal pair, the top-left pixel of each 2x2 block, or the top-left pixel of each 4x4 block.

Two markers travel with the input pixels. A start-of-field flag sits on the first pixel of a field and sets the row count to zero. An end-of-line flag sits on the last pixel of each line. A two-bit lane offset per plane chooses the byte lane that receives the first kept byte of every line, so a plane can start at any byte address. At the end of a line a partial word is flushed with only its written lanes enabled. If any of the three FIFOs reports full, the input is held off through a ready signal, so no sample is lost.

Top module: `yuv_plane_splitter`

## Requirements
- R1: After reset, with no input offered, no plane writes and `in_ready` is high while no FIFO is full.
- R2: Every accepted pixel's luma byte goes into the Y plane. Bytes fill a word from bits 7:0 upward in arrival order: lane k holds bits 8k+7:8k.
- R3: With `mode`=0, the U and V bytes of every pixel are kept.
- R4: With `mode`=1, chroma is kept only for pixels at even column index. Column 0 is the first pixel of a line.
- R5: With `mode`=2, chroma is kept only where both the column and the row index are even. Odd rows produce no U or V writes.
- R6: With `mode`=3, chroma is kept only where both the column and the row index are multiples of 4.
- R7: The first byte kept on each line of a plane lands in the lane given by that plane's offset input. Lanes below it have their enable low and their data zero.
- R8: On the pixel that carries `in_eol`, every plane holding unwritten bytes writes a partial word. Only the filled lanes are enabled, and the unused lanes read zero.
- R9: Within a line, a plane writes as soon as lane 3 is filled, and in the same cycle as the pixel that filled it.
- R10: While any `*_full` input is high, `in_ready` is low, no plane writes, and the stalled pixel is later taken exactly once.
- R11: A pixel with `in_sof` is taken as row 0, column 0. The pixel after an `in_eol` pixel is column 0 of the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Chroma pattern: 0 all, 1 pairs, 2 2x2, 3 4x4 |
| y_lane | input | 2 | Starting byte lane of each Y line |
| u_lane | input | 2 | Starting byte lane of each U line |
| v_lane | input | 2 | Starting byte lane of each V line |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel taken when high with in_valid |
| in_y | input | 8 | Luma byte |
| in_u | input | 8 | U byte |
| in_v | input | 8 | V byte |
| in_sof | input | 1 | First pixel of a field |
| in_eol | input | 1 | Last pixel of a line |
| y_full | input | 1 | Y FIFO full |
| u_full | input | 1 | U FIFO full |
| v_full | input | 1 | V FIFO full |
| y_wr | output | 1 | Y word write strobe |
| y_data | output | 32 | Y word |
| y_be | output | 4 | Y lane enables |
| u_wr | output | 1 | U word write strobe |
| u_data | output | 32 | U word |
| u_be | output | 4 | U lane enables |
| v_wr | output | 1 | V word write strobe |
| v_data | output | 32 | V word |
| v_be | output | 4 | V lane enables |

## Verification
If the column or row position goes wrong, the ports show chroma bytes from the wrong pixels or chroma writes on rows that should be silent. This appears in the next chroma word of the line, at most four kept samples later. A wrong lane pointer or a stale accumulator shows up at the next write as a shifted byte, a wrong enable mask or leftover data in a lane. Bytes left behind at line end show up as words missing from the scoreboard queues. A backpressure fault shows up as a write while a full flag is high, or as a word written twice.

// File: rtl/yuv_split_pkg.sv
// Shared definitions for the planar YUV splitter.
// Assumes three planes in fixed order: luma, U, V.
package yuv_split_pkg;

    typedef enum logic [1:0] {
        SUB_FULL = 2'd0,   // keep chroma on every pixel
        SUB_PAIR = 2'd1,   // keep on even columns
        SUB_QUAD = 2'd2,   // keep on even columns of even rows
        SUB_SIXT = 2'd3    // keep at multiples of 4 in both axes
    } sub_mode_e;

    localparam int PLANES  = 3;
    localparam int PLANE_Y = 0;
    localparam int PLANE_U = 1;
    localparam int PLANE_V = 2;

endpackage

// File: rtl/yuv_pos_tracker.sv
// Tracks the column and row position (modulo the largest decimation) of
// each accepted pixel and decides whether its chroma is kept.
// Assumes in_sof marks row 0 col 0 and in_eol marks the last pixel of a line.
module yuv_pos_tracker
    import yuv_split_pkg::*;
#(
    parameter int MAX_DECIM = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      beat,
    input  logic      sof,
    input  logic      eol,
    input  sub_mode_e mode,
    output logic      line_first,
    output logic      keep_chroma
);
    localparam int CW = $clog2(MAX_DECIM);

    logic [CW-1:0] col_q, row_q;
    logic [CW-1:0] col_now, row_now;
    logic          start_q;

    // Current position: a field start forces row 0, col 0.
    always_comb begin
        col_now    = sof ? '0 : col_q;
        row_now    = sof ? '0 : row_q;
        line_first = sof | start_q;
    end

    // Chroma keep decision from the position and the selected pattern.
    always_comb begin
        case (mode)
            SUB_FULL: keep_chroma = 1'b1;
            SUB_PAIR: keep_chroma = ~col_now[0];
            SUB_QUAD: keep_chroma = ~col_now[0] & ~row_now[0];
            default:  keep_chroma = (col_now == '0) && (row_now == '0);
        endcase
    end

    // Advance the column on each pixel; wrap to a new row after end of line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            row_q   <= '0;
            start_q <= 1'b1;
        end else if (beat) begin
            if (eol) begin
                col_q   <= '0;
                row_q   <= row_now + CW'(1);
                start_q <= 1'b1;
            end else begin
                col_q   <= col_now + CW'(1);
                row_q   <= row_now;
                start_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/yuv_word_packer.sv
// Packs kept bytes of one plane into words, low lane first.
// The write strobe and word are combinational in the cycle the completing
// byte is accepted. Assumes beat is only high when the FIFO has room.
module yuv_word_packer #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     beat,
    input  logic                     take,
    input  logic                     first,
    input  logic                     last,
    input  logic [$clog2(LANES)-1:0] lane_off,
    input  logic [BYTE_W-1:0]        din,
    output logic                     wr,
    output logic [BYTE_W*LANES-1:0]  word,
    output logic [LANES-1:0]         be
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LW     = $clog2(LANES);

    logic [WORD_W-1:0] acc_q, nxt_w;
    logic [LANES-1:0]  be_q, nxt_be;
    logic [LW-1:0]     lane_q, cur_lane;

    // Merge the new byte into the held partial word; a line start discards it.
    always_comb begin
        cur_lane = first ? lane_off : lane_q;
        nxt_w    = first ? '0 : acc_q;
        nxt_be   = first ? '0 : be_q;
        if (take) begin
            nxt_w[cur_lane*BYTE_W +: BYTE_W] = din;
            nxt_be[cur_lane]                 = 1'b1;
        end
        wr   = beat && ((take && (cur_lane == LW'(LANES - 1))) ||
                        (last && (nxt_be != '0)));
        word = nxt_w;
        be   = nxt_be;
    end

    // Hold the partial word; clear it whenever it has been written out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            be_q   <= '0;
            lane_q <= '0;
        end else if (beat) begin
            acc_q  <= wr ? '0 : nxt_w;
            be_q   <= wr ? '0 : nxt_be;
            lane_q <= take ? cur_lane + LW'(1) : cur_lane;
        end
    end

endmodule

// File: rtl/yuv_plane_splitter.sv
// Splits full-resolution YUV pixels into three packed planes with chroma
// decimation chosen by mode. Assumes mode and lane offsets only change
// between lines. Input is stalled while any FIFO is full.
module yuv_plane_splitter
    import yuv_split_pkg::*;
#(
    parameter  int BYTE_W    = 8,
    parameter  int LANES     = 4,
    parameter  int MAX_DECIM = 4,
    localparam int LW        = $clog2(LANES),
    localparam int WORD_W    = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [LW-1:0]     y_lane,
    input  logic [LW-1:0]     u_lane,
    input  logic [LW-1:0]     v_lane,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_y,
    input  logic [BYTE_W-1:0] in_u,
    input  logic [BYTE_W-1:0] in_v,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic              y_full,
    input  logic              u_full,
    input  logic              v_full,
    output logic              y_wr,
    output logic [WORD_W-1:0] y_data,
    output logic [LANES-1:0]  y_be,
    output logic              u_wr,
    output logic [WORD_W-1:0] u_data,
    output logic [LANES-1:0]  u_be,
    output logic              v_wr,
    output logic [WORD_W-1:0] v_data,
    output logic [LANES-1:0]  v_be
);
    logic                beat, line_first, keep_c;
    logic [BYTE_W-1:0]   din_a  [PLANES];
    logic [LW-1:0]       off_a  [PLANES];
    logic                take_a [PLANES];
    logic                wr_a   [PLANES];
    logic [WORD_W-1:0]   word_a [PLANES];
    logic [LANES-1:0]    be_a   [PLANES];

    // Stall the source whenever any destination cannot take a word.
    always_comb begin
        in_ready = ~(y_full | u_full | v_full);
        beat     = in_valid & in_ready;
    end

    yuv_pos_tracker #(.MAX_DECIM(MAX_DECIM)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (beat),
        .sof        (in_sof),
        .eol        (in_eol),
        .mode       (sub_mode_e'(mode)),
        .line_first (line_first),
        .keep_chroma(keep_c)
    );

    // Route each plane's byte and offset; luma is taken on every pixel.
    always_comb begin
        din_a[PLANE_Y]  = in_y;
        din_a[PLANE_U]  = in_u;
        din_a[PLANE_V]  = in_v;
        off_a[PLANE_Y]  = y_lane;
        off_a[PLANE_U]  = u_lane;
        off_a[PLANE_V]  = v_lane;
        take_a[PLANE_Y] = beat;
        take_a[PLANE_U] = beat & keep_c;
        take_a[PLANE_V] = beat & keep_c;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        yuv_word_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
            .clk     (clk),
            .rst_n   (rst_n),
            .beat    (beat),
            .take    (take_a[p]),
            .first   (line_first),
            .last    (in_eol),
            .lane_off(off_a[p]),
            .din     (din_a[p]),
            .wr      (wr_a[p]),
            .word    (word_a[p]),
            .be      (be_a[p])
        );
    end

    // Expose the per-plane packer outputs on the named ports.
    always_comb begin
        y_wr = wr_a[PLANE_Y]; y_data = word_a[PLANE_Y]; y_be = be_a[PLANE_Y];
        u_wr = wr_a[PLANE_U]; u_data = word_a[PLANE_U]; u_be = be_a[PLANE_U];
        v_wr = wr_a[PLANE_V]; v_data = word_a[PLANE_V]; v_be = be_a[PLANE_V];
    end

endmodule

// Port-level properties of the splitter.
module yuv_plane_splitter_chk #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [LW-1:0]    y_lane,
    input logic [LW-1:0]    u_lane,
    input logic [LW-1:0]    v_lane,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_eol,
    input logic             y_full,
    input logic             u_full,
    input logic             v_full,
    input logic             y_wr,
    input logic [LANES-1:0] y_be,
    input logic             u_wr,
    input logic [LANES-1:0] u_be,
    input logic             v_wr,
    input logic [LANES-1:0] v_be
);
    assert_write_needs_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (y_wr || u_wr || v_wr) |-> (in_valid && in_ready));

    assert_stall_on_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (y_full || u_full || v_full) |-> !in_ready);

    assert_mid_full_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (y_wr && !in_eol) |-> y_be[LANES-1]);

    assert_mid_full_u_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (u_wr && !in_eol) |-> u_be[LANES-1]);

    assert_mid_full_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (v_wr && !in_eol) |-> v_be[LANES-1]);

    assert_be_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        y_wr |-> (y_be != '0));

    assert_chroma_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (u_lane == v_lane) |-> (u_wr == v_wr));

    assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && y_lane == u_lane) |-> (y_wr == u_wr));
endmodule

bind yuv_plane_splitter yuv_plane_splitter_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .y_lane(y_lane), .u_lane(u_lane),
    .v_lane(v_lane), .in_valid(in_valid), .in_ready(in_ready), .in_eol(in_eol),
    .y_full(y_full), .u_full(u_full), .v_full(v_full),
    .y_wr(y_wr), .y_be(y_be), .u_wr(u_wr), .u_be(u_be), .v_wr(v_wr), .v_be(v_be)
);

// File: tb/yuv_plane_splitter_bench.sv
module yuv_plane_splitter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  y_lane = 2'd0, u_lane = 2'd0, v_lane = 2'd0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [7:0]  in_y = 8'd0, in_u = 8'd0, in_v = 8'd0;
    logic        y_full = 1'b0, u_full = 1'b0, v_full = 1'b0;
    logic        in_ready;
    logic        y_wr, u_wr, v_wr;
    logic [31:0] y_data, u_data, v_data;
    logic [3:0]  y_be, u_be, v_be;

    int    n_chk = 0, n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    // Bench reference state.
    int          m_row = 0, m_col = 0;
    int          m_lane [3];
    logic [31:0] m_acc  [3];
    logic [3:0]  m_be   [3];
    logic [35:0] q_y[$], q_u[$], q_v[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    yuv_plane_splitter u_yuv_plane_splitter (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .y_lane(y_lane), .u_lane(u_lane), .v_lane(v_lane),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_u(in_u), .in_v(in_v),
        .in_sof(in_sof), .in_eol(in_eol),
        .y_full(y_full), .u_full(u_full), .v_full(v_full),
        .y_wr(y_wr), .y_data(y_data), .y_be(y_be),
        .u_wr(u_wr), .u_data(u_data), .u_be(u_be),
        .v_wr(v_wr), .v_data(v_data), .v_be(v_be)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void push_exp(input int p, input logic [35:0] v);
        case (p)
            0: q_y.push_back(v);
            1: q_u.push_back(v);
            default: q_v.push_back(v);
        endcase
    endfunction

    // Reference: positions, keep rule and packing from the requirements.
    task automatic model_px(input logic [7:0] y, u, v, input bit sof, eol);
        bit keepc, first;
        logic [7:0] b;
        int off;
        if (sof) begin m_row = 0; m_col = 0; end
        first = (m_col == 0);
        case (mode)
            2'd0: keepc = 1'b1;
            2'd1: keepc = (m_col % 2 == 0);
            2'd2: keepc = (m_col % 2 == 0) && (m_row % 2 == 0);
            default: keepc = (m_col % 4 == 0) && (m_row % 4 == 0);
        endcase
        for (int p = 0; p < 3; p++) begin
            off = (p == 0) ? int'(y_lane) : (p == 1) ? int'(u_lane) : int'(v_lane);
            b   = (p == 0) ? y : (p == 1) ? u : v;
            if (first) begin m_lane[p] = off; m_acc[p] = '0; m_be[p] = '0; end
            if (p == 0 || keepc) begin
                m_acc[p][m_lane[p]*8 +: 8] = b;
                m_be[p][m_lane[p]] = 1'b1;
                if (m_lane[p] == 3 || eol) begin
                    push_exp(p, {m_be[p], m_acc[p]});
                    m_acc[p] = '0; m_be[p] = '0; m_lane[p] = 0;
                end else begin
                    m_lane[p]++;
                end
            end else if (eol && m_be[p] != 4'd0) begin
                push_exp(p, {m_be[p], m_acc[p]});
                m_acc[p] = '0; m_be[p] = '0;
            end
        end
        if (eol) begin m_col = 0; m_row++; end else m_col++;
    endtask

    // Driver: queue the expectation, then offer the pixel until taken.
    task automatic send_px(input logic [7:0] y, u, v, input bit sof, eol,
                           input int stall);
        model_px(y, u, v, sof, eol);
        in_y = y; in_u = u; in_v = v; in_sof = sof; in_eol = eol;
        in_valid = 1'b1;
        if (stall > 0) begin
            u_full = 1'b1;
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                check(!in_ready, "R10", "ready while full", 36'(in_ready), 36'd0);
                check(!(y_wr | u_wr | v_wr), "R10", "write while full",
                      36'({y_wr, u_wr, v_wr}), 36'd0);
                @(posedge clk); #1;
            end
            u_full = 1'b0;
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] md, input logic [1:0] oy, ou, ov,
                              input int width, lines, stall_at, input string req);
        mode = md; y_lane = oy; u_lane = ou; v_lane = ov; cur_req = req;
        for (int r = 0; r < lines; r++) begin
            for (int c = 0; c < width; c++) begin
                send_px(8'(r*16 + c), 8'(8'h80 + r*16 + c), 8'(8'hC0 ^ (r*16 + c)),
                        (r == 0 && c == 0), (c == width - 1),
                        (r*width + c == stall_at) ? 3 : 0);
            end
        end
    endtask

    // Monitor: pop and compare each word the design writes.
    always @(negedge clk) begin
        logic [35:0] e;
        if (rst_n && !done) begin
            if (y_wr) begin
                if (q_y.size() == 0) check(0, cur_req, "Y unexpected", {y_be, y_data}, 36'd0);
                else begin e = q_y.pop_front(); check({y_be, y_data} == e, cur_req, "Y word", {y_be, y_data}, e); end
            end
            if (u_wr) begin
                if (q_u.size() == 0) check(0, cur_req, "U unexpected", {u_be, u_data}, 36'd0);
                else begin e = q_u.pop_front(); check({u_be, u_data} == e, cur_req, "U word", {u_be, u_data}, e); end
            end
            if (v_wr) begin
                if (q_v.size() == 0) check(0, cur_req, "V unexpected", {v_be, v_data}, 36'd0);
                else begin e = q_v.pop_front(); check({v_be, v_data} == e, cur_req, "V word", {v_be, v_data}, e); end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet and ready after reset
        check(in_ready, "R1", "ready after reset", 36'(in_ready), 36'd1);
        check(!(y_wr | u_wr | v_wr), "R1", "idle writes", 36'({y_wr, u_wr, v_wr}), 36'd0);
        @(posedge clk); #1;

        send_frame(2'd0, 2'd0, 2'd0, 2'd0, 8, 2, -1, "R2/R3");
        send_frame(2'd1, 2'd1, 2'd2, 2'd3, 7, 3, -1, "R4/R7/R8");
        send_frame(2'd2, 2'd0, 2'd1, 2'd0, 6, 4, 9, "R5/R9/R10");
        send_frame(2'd3, 2'd2, 2'd0, 2'd1, 9, 8, 20, "R6/R7/R10");
        // R11: new field restarts at row 0 mid-pattern
        send_frame(2'd3, 2'd0, 2'd3, 2'd3, 5, 3, -1, "R11");
        send_frame(2'd2, 2'd3, 2'd3, 2'd2, 3, 3, -1, "R11/R8");

        repeat (3) @(posedge clk);
        #1;
        check(q_y.size() == 0, "R8", "Y words left", 36'(q_y.size()), 36'd0);
        check(q_u.size() == 0, "R8", "U words left", 36'(q_u.size()), 36'd0);
        check(q_v.size() == 0, "R8", "V words left", 36'(q_v.size()), 36'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule